// File: doc/BRIEF.md
# Chained Multiply-Add Big-Integer Scaler

This block multiplies an unsigned 64-bit scalar by an unsigned multi-limb integer held in a small register file. One limb is processed per clock. In each step the scalar is multiplied by one source limb, and the current carry word is added to that product. The 128-bit sum splits in two: the low half becomes a result limb and the high half replaces the carry word. Because the carry register is both the addend and the upper output of every step, the partial products chain from limb to limb without a separate carry-propagate adder. With four steps and a carry register that starts at zero, a 256-bit operand scaled by a 64-bit scalar gives a 320-bit product. Its top limb is the final carry.

Software loads operands through a host write port and reads results back through a combinational read port. A job starts with a one-cycle `start` pulse. The pulse supplies the limb count, the scalar register index, the source and destination base indices, and the carry register index. `busy` stays high while steps run, and `done` pulses once at the end. The steps behave exactly like single multiply-add operations issued one after another on ascending register indices. A later step therefore sees whatever an earlier step wrote.

Top module: `bigscale_mac_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all 32 registers read back as zero.
- R2: While idle, a host write with `host_we`=1 stores `host_wdata` at `host_waddr` on the clock edge, and `host_rdata` shows the register at `host_raddr` in the same cycle without a clock delay. While idle with no host write, no register changes.
- R3: Step i (0-based) computes P = S*X + K. S is the scalar register, X is register (src_base+i), K is the carry register, and all three are unsigned 64-bit values. P[63:0] is written to register (dst_base+i) and P[127:64] is written to the carry register. With four steps and the carry cleared to zero first, {carry, dst+3..dst} equals the 320-bit product.
- R4: Register indices are 5 bits wide and wrap modulo 32. Step i therefore uses (src_base+i) mod 32 and (dst_base+i) mod 32.
- R5: Each step reads the register contents left by all earlier steps, including the scalar register or source limbs that an earlier result limb has overwritten. This matches issuing the single-step operation sequentially.
- R6: If a step's destination index equals the carry index, the register keeps the high half of P. The carry write takes priority over the limb write in the same cycle.
- R7: For a limb count N>0 accepted at a clock edge, `busy` is high for exactly the N following cycles. `done` is high for exactly one cycle, the cycle after the last write, and `busy` is never high at the same time as `done`.
- R8: A start with limb count 0 leaves every register unchanged, never raises `busy`, and pulses `done` in the cycle after the start edge.
- R9: While `busy` is high, `start` and host writes are ignored.
- R10: The all-ones case (every operand limb and the scalar equal to 2^64-1, carry starting at 0) gives the exact 320-bit product with no lost bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write enable (honoured only when idle) |
| host_waddr | input | 5 | Host write register index |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host readback register index |
| host_rdata | output | 64 | Combinational readback data |
| start | input | 1 | One-cycle job request (honoured only when idle) |
| vlen | input | 6 | Number of limbs to process, 0 to 32 |
| scalar_idx | input | 5 | Register index of the scalar multiplier |
| src_base | input | 5 | Register index of the first source limb |
| dst_base | input | 5 | Register index of the first result limb |
| carry_idx | input | 5 | Register index of the carry word |
| busy | output | 1 | High while steps are running |
| done | output | 1 | One-cycle completion pulse |

## Verification
In a single cycle the step write of the result limb and the write-back of the carry word can target the same register. The bench provokes this by setting the destination range so that it runs over the carry index. It then judges the outcome by reading that register back, which must hold the high half. A second coincidence also gets attention: a step whose earlier result overwrote a later source limb or the scalar. For both, the sweep compares every register against a step-by-step arithmetic model, over limb counts 0 to 8 and several base layouts, including wrapping ones.

// File: rtl/bigscale_pkg.sv
package bigscale_pkg;

    localparam int LIMB_W = 64;
    localparam int REG_N  = 32;
    localparam int IDX_W  = $clog2(REG_N);
    localparam int LEN_W  = $clog2(REG_N + 1);
    localparam int PROD_W = 2 * LIMB_W;

    typedef logic [LIMB_W-1:0] limb_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        limb_t hi;
        limb_t lo;
    } wide_t;

    typedef struct packed {
        logic  en;
        idx_t  addr;
        limb_t data;
    } wr_t;

    typedef struct packed {
        len_t len;
        idx_t scal;
        idx_t src;
        idx_t dst;
        idx_t cry;
    } job_t;

    function automatic wide_t mul_add(input limb_t x, input limb_t y, input limb_t z);
        logic [PROD_W-1:0] s;
        s = {{LIMB_W{1'b0}}, x} * {{LIMB_W{1'b0}}, y} + {{LIMB_W{1'b0}}, z};
        return wide_t'(s);
    endfunction

endpackage

// File: rtl/bigscale_regfile.sv
module bigscale_regfile
    import bigscale_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   host_w,
    input  wr_t   limb_w,
    input  wr_t   carry_w,
    input  idx_t  rd_scal,
    input  idx_t  rd_src,
    input  idx_t  rd_cry,
    input  idx_t  rd_host,
    output limb_t q_scal,
    output limb_t q_src,
    output limb_t q_cry,
    output limb_t q_host
);

    limb_t mem [REG_N];

    always_ff @(posedge clk) begin
        for (int k = 0; k < REG_N; k++) begin
            if (rst) begin
                mem[k] <= '0;
            end else if (carry_w.en && carry_w.addr == idx_t'(k)) begin
                mem[k] <= carry_w.data;
            end else if (limb_w.en && limb_w.addr == idx_t'(k)) begin
                mem[k] <= limb_w.data;
            end else if (host_w.en && host_w.addr == idx_t'(k)) begin
                mem[k] <= host_w.data;
            end
        end
    end

    assign q_scal = mem[rd_scal];
    assign q_src  = mem[rd_src];
    assign q_cry  = mem[rd_cry];
    assign q_host = mem[rd_host];

endmodule

// File: rtl/bigscale_step.sv
module bigscale_step
    import bigscale_pkg::*;
(
    input  limb_t scal,
    input  limb_t limb,
    input  limb_t carry_in,
    output limb_t res_lo,
    output limb_t carry_out
);

    wide_t sum;

    always_comb begin
        sum       = mul_add(scal, limb, carry_in);
        res_lo    = sum.lo;
        carry_out = sum.hi;
    end

endmodule

// File: rtl/bigscale_ctrl.sv
module bigscale_ctrl
    import bigscale_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  job_t req,
    output job_t job,
    output len_t step,
    output logic busy,
    output logic done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            step <= '0;
            job  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    job  <= req;
                    step <= '0;
                    if (req.len == '0) begin
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                    end
                end
            end else begin
                step <= step + len_t'(1);
                if (step == job.len - len_t'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bigscale_mac_unit.sv
module bigscale_mac_unit
    import bigscale_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         host_we,
    input  logic [4:0]   host_waddr,
    input  logic [63:0]  host_wdata,
    input  logic [4:0]   host_raddr,
    output logic [63:0]  host_rdata,
    input  logic         start,
    input  logic [5:0]   vlen,
    input  logic [4:0]   scalar_idx,
    input  logic [4:0]   src_base,
    input  logic [4:0]   dst_base,
    input  logic [4:0]   carry_idx,
    output logic         busy,
    output logic         done
);

    job_t  req, job;
    len_t  step;
    idx_t  src_i, dst_i;
    limb_t q_scal, q_src, q_cry, res_lo, carry_out;
    wr_t   host_w, limb_w, carry_w;

    assign req = '{len: len_t'(vlen), scal: idx_t'(scalar_idx), src: idx_t'(src_base),
                   dst: idx_t'(dst_base), cry: idx_t'(carry_idx)};

    bigscale_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .req   (req),
        .job   (job),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    assign src_i = job.src + idx_t'(step);
    assign dst_i = job.dst + idx_t'(step);

    bigscale_step u_step (
        .scal      (q_scal),
        .limb      (q_src),
        .carry_in  (q_cry),
        .res_lo    (res_lo),
        .carry_out (carry_out)
    );

    assign host_w  = '{en: host_we && !busy, addr: idx_t'(host_waddr), data: limb_t'(host_wdata)};
    assign limb_w  = '{en: busy, addr: dst_i,   data: res_lo};
    assign carry_w = '{en: busy, addr: job.cry, data: carry_out};

    bigscale_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .host_w  (host_w),
        .limb_w  (limb_w),
        .carry_w (carry_w),
        .rd_scal (job.scal),
        .rd_src  (src_i),
        .rd_cry  (job.cry),
        .rd_host (idx_t'(host_raddr)),
        .q_scal  (q_scal),
        .q_src   (q_src),
        .q_cry   (q_cry),
        .q_host  (host_rdata)
    );

endmodule

// File: rtl/bigscale_mac_unit_chk.sv
module bigscale_mac_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [5:0]  vlen,
    input logic        host_we,
    input logic [4:0]  host_raddr,
    input logic [63:0] host_rdata,
    input logic        busy,
    input logic        done
);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && vlen != 6'd0) |=> (busy && !done));

    p_zero_len_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && vlen == 6'd0) |=> (done && !busy));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !host_we) |=> ((host_raddr != $past(host_raddr)) || $stable(host_rdata)));

endmodule

bind bigscale_mac_unit bigscale_mac_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vlen       (vlen),
    .host_we    (host_we),
    .host_raddr (host_raddr),
    .host_rdata (host_rdata),
    .busy       (busy),
    .done       (done)
);

// File: tb/bigscale_mac_unit_bench.sv
module bigscale_mac_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [4:0]  host_waddr = '0;
    logic [63:0] host_wdata = '0;
    logic [4:0]  host_raddr = '0;
    logic [63:0] host_rdata;
    logic        start = 1'b0;
    logic [5:0]  vlen = '0;
    logic [4:0]  scalar_idx = '0, src_base = '0, dst_base = '0, carry_idx = '0;
    logic        busy, done;

    int checks = 0;
    int errors = 0;
    logic [63:0] m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    bigscale_mac_unit u_bigscale_mac_unit (
        .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
        .start(start), .vlen(vlen), .scalar_idx(scalar_idx), .src_base(src_base),
        .dst_base(dst_base), .carry_idx(carry_idx), .busy(busy), .done(done)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic hwrite(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [63:0] d);
        host_raddr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic verify_all(input string tag);
        logic [63:0] d;
        @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            hread(5'(k), d);
            chk(tag, d, m[k]);
        end
    endtask

    // step-by-step arithmetic model of the requirements (R3, R4, R5, R6)
    task automatic model_run(input int n, input logic [4:0] a, input logic [4:0] b,
                             input logic [4:0] d, input logic [4:0] c);
        logic [127:0] p;
        for (int i = 0; i < n; i++) begin
            p = {64'd0, m[a]} * {64'd0, m[5'(b + 5'(i))]} + {64'd0, m[c]};
            m[5'(d + 5'(i))] = p[63:0];
            m[c] = p[127:64];
        end
    endtask

    task automatic run_job(input string tag, input int n, input logic [4:0] a,
                           input logic [4:0] b, input logic [4:0] d, input logic [4:0] c);
        int bc;
        bc = 0;
        @(negedge clk);
        start = 1'b1; vlen = 6'(n); scalar_idx = a; src_base = b; dst_base = d; carry_idx = c;
        @(negedge clk);
        start = 1'b0;
        while (busy && bc < 40) begin
            bc++;
            chk({tag, " R7 done low while busy"}, 64'(done), 64'd0);
            @(negedge clk);
        end
        chk({tag, " R7 busy cycles"}, 64'(bc), 64'(n));
        chk({tag, " R7/R8 done pulse"}, 64'(done), 64'd1);
        @(negedge clk);
        chk({tag, " R7 done single"}, 64'(done), 64'd0);
        model_run(n, a, b, d, c);
    endtask

    task automatic preload(input logic [4:0] c);
        for (int k = 0; k < 32; k++) begin
            m[k] = rnd64();
            if (5'(k) == c) m[k] = 64'd0;
            hwrite(5'(k), m[k]);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0]  d;
        logic [319:0] wide, got;
        for (int k = 0; k < 32; k++) m[k] = 64'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        verify_all("R1 regs zero");

        // R2: write and same-cycle readback
        hwrite(5'd7, 64'hDEAD_BEEF_0123_4567);
        m[7] = 64'hDEAD_BEEF_0123_4567;
        hread(5'd7, d);
        chk("R2 readback", d, m[7]);

        // R3: 256-bit by 64-bit product against wide reference
        for (int t = 0; t < 6; t++) begin
            preload(5'd24);
            run_job("R3", 4, 5'd3, 5'd8, 5'd16, 5'd24);
            verify_all("R3 regs");
            got = '0;
            for (int i = 0; i < 4; i++) begin
                hread(5'(16 + i), d);
                got[64*i +: 64] = d;
            end
            hread(5'd24, d);
            got[319:256] = d;
            wide = 320'(m[3]) * {64'd0, m[11], m[10], m[9], m[8]};
            chk("R3 wide lo", got[63:0], wide[63:0]);
            chk("R3 wide top", got[319:256], wide[319:256]);
        end

        // sweep limb counts over several layouts
        for (int n = 0; n <= 8; n++) begin
            preload(5'd24);
            run_job("R3 sweep", n, 5'd3, 5'd8, 5'd16, 5'd24);
            verify_all(n == 0 ? "R8 zero length unchanged" : "R3 sweep regs");
            preload(5'd5);
            run_job("R4 wrap", n, 5'd0, 5'd30, 5'd27, 5'd5);
            verify_all("R4 wrap regs");
            preload(5'd2);
            run_job("R5 overlap", n, 5'd1, 5'd10, 5'd11, 5'd2);
            verify_all("R5 overlap regs");
            preload(5'd22);
            run_job("R6 clash", n, 5'd4, 5'd12, 5'd20, 5'd22);
            verify_all("R6 clash regs");
            preload(5'd9);
            run_job("R5 scalar overwritten", n, 5'd14, 5'd12, 5'd13, 5'd9);
            verify_all("R5 scalar regs");
        end

        // R10 all-ones
        for (int k = 0; k < 32; k++) begin
            m[k] = '1;
            if (k == 24) m[k] = 64'd0;
            hwrite(5'(k), m[k]);
        end
        run_job("R10", 4, 5'd3, 5'd8, 5'd16, 5'd24);
        verify_all("R10 regs");
        wide = 320'({64{1'b1}}) * {64'd0, {256{1'b1}}};
        for (int i = 0; i < 4; i++) begin
            hread(5'(16 + i), d);
            chk("R10 limb", d, wide[64*i +: 64]);
        end
        hread(5'd24, d);
        chk("R10 top", d, wide[319:256]);

        // R9: start and host write during busy are ignored
        preload(5'd24);
        @(negedge clk);
        start = 1'b1; vlen = 6'd8; scalar_idx = 5'd3; src_base = 5'd8;
        dst_base = 5'd16; carry_idx = 5'd24;
        @(negedge clk);
        start = 1'b1; vlen = 6'd2; scalar_idx = 5'd0; src_base = 5'd0;
        dst_base = 5'd0; carry_idx = 5'd1;
        host_we = 1'b1; host_waddr = 5'd31; host_wdata = ~m[31];
        @(negedge clk);
        start = 1'b0; host_we = 1'b0;
        while (busy) @(negedge clk);
        chk("R9 done", 64'(done), 64'd1);
        model_run(8, 5'd3, 5'd8, 5'd16, 5'd24);
        repeat (3) @(negedge clk);
        chk("R9 no restart", 64'(busy), 64'd0);
        verify_all("R9 regs");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule